// File: doc/BRIEF.md
# Page-Buffered Write and Address Counter Back End

This block is the memory-side half of a byte-addressed serial memory. A bus engine in front of it decodes the wire protocol. It hands this block several kinds of traffic: an address to load, incoming write bytes, requests for read bytes, and a stop pulse. The block owns the internal address counter. It gathers write bytes into a one-page buffer and, after a stop, copies the gathered bytes into an external synchronous array. While that copy runs, the block holds a busy flag for a programmable number of clocks.

Write bytes advance only the in-page part of the counter. A long burst therefore folds back to the start of the same page, and later bytes replace earlier ones at the same offset. Reads advance the whole counter and roll from the top of the array back to address zero. A read that carries no address of its own starts wherever the counter was left. That point is one past the last byte touched, subject to the same page fold for writes.

Write bytes and read bytes move as valid/ready streams. A byte moves on a clock edge where both valid and ready are high. The block drops `wr_ready` and `rq_ready` whenever it cannot take more. On the read side, `rd_valid` and `rd_data` are held unchanged until `rd_ready` is seen. Load address, stop, write protect and busy are plain level signals. The array sits outside the block and returns read data one clock after `arr_re`.

Top module: `page_write_backend`

## Requirements
- R1: After reset the counter is zero, busy is low and no read byte is offered, so a read without a prior load returns the array byte at address 0.
- R2: An accepted write byte is buffered at offset `cur[PAGE_W-1:0]` of the current page. Only those low bits then increment, wrapping from the last offset to offset 0, and a later byte at an already-filled offset replaces the earlier one.
- R3: An accepted read request returns the array byte at the counter, and the full ADDR_W-bit counter then increments, wrapping from the top address to 0.
- R4: A read with no load before it continues from the counter left by the previous access. After a write burst, that is the page-folded position one past the last byte written.
- R5: A stop with at least one buffered byte and `wp` low raises busy on the next cycle for exactly WCYC cycles. During that window it writes each received offset to the array at its page address, and the array bytes of that page that were not received keep their old value.
- R6: A stop with no buffered byte, or with `wp` high, leaves busy low, writes nothing to the array and discards the buffer.
- R7: While busy is high, `wr_ready` and `rq_ready` are low, and a load or stop presented in that time has no effect on the counter or the array.
- R8: Once `rd_valid` rises it stays high with `rd_data` unchanged until a cycle with `rd_ready` high, and no further read request is accepted before that byte is taken.
- R9: A load sets the counter to `ld_addr` and discards any bytes buffered so far.
- R10: `rq_ready` is low while write bytes are buffered, and `wr_ready` is low while a read byte is in flight or offered. Within one cycle, stop takes priority over load, load over write, and write over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect, sampled with stop |
| ld_valid | input | 1 | Load-address strobe |
| ld_addr | input | ADDR_W | Address to load into the counter |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte accepted when high with valid |
| wr_data | input | DATA_W | Write byte |
| stop | input | 1 | Stop pulse from the bus engine |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted when high with valid |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken when high with valid |
| rd_data | output | DATA_W | Read byte |
| busy | output | 1 | Timed array write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_re | output | 1 | Array read enable |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data, one cycle after arr_re |

## Verification
The bench builds the block with ADDR_W=10, so the array has only eight 128-byte pages. A short sequential read can then step from the top address back to zero. The page size stays at its default, which keeps the in-page fold and the overwrite behaviour of 130-byte bursts exactly as deployed. WCYC is set to 200 clocks instead of a ten-millisecond count. That value is still above the 128-cycle buffer scan, so the exact busy length is measurable on every commit.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_STOP,
    OP_LOAD,
    OP_WRITE,
    OP_READ
  } op_e;
endpackage

// File: rtl/pgc_addr_ctr.sv
module pgc_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pgc_pkg::op_e      op,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  import pgc_pkg::*;

  logic [PAGE_W-1:0] low_next;

  assign low_next = cur_addr[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  cur_addr <= ld_addr;
        OP_WRITE: cur_addr <= {cur_addr[ADDR_W-1:PAGE_W], low_next};
        OP_READ:  cur_addr <= cur_addr + 1'b1;
        default:  cur_addr <= cur_addr;
      endcase
    end
  end
endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[g] <= 1'b0;
      else if (clear)  vld_q[g] <= 1'b0;
      else if (hit)    vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data;
    end
  end

  assign rd_data = data_q[rd_off];
  assign rd_vld  = vld_q[rd_off];
  assign any_vld = |vld_q;
endmodule

// File: rtl/pgc_commit_seq.sv
module pgc_commit_seq #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 7,
  parameter int WCYC   = 1000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] page_in,
  output logic                     busy,
  output logic                     scan_act,
  output logic [PAGE_W-1:0]        scan_idx,
  output logic [ADDR_W-PAGE_W-1:0] page_q,
  output logic                     done
);
  localparam int TW = $clog2(WCYC + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(WCYC - 1);
  localparam logic [PAGE_W-1:0] LAST = '1;

  logic [TW-1:0] timer_q;

  assign done = busy && (timer_q == '0) && !scan_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      scan_act <= 1'b0;
      scan_idx <= '0;
      timer_q  <= '0;
      page_q   <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      scan_act <= 1'b1;
      scan_idx <= '0;
      timer_q  <= T_LOAD;
      page_q   <= page_in;
    end else if (busy) begin
      if (scan_act) begin
        scan_idx <= scan_idx + 1'b1;
        if (scan_idx == LAST) scan_act <= 1'b0;
      end
      if (timer_q != '0)  timer_q <= timer_q - 1'b1;
      else if (!scan_act) busy    <= 1'b0;
    end
  end
endmodule

// File: rtl/pgc_rd_stage.sv
module pgc_rd_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              pend
);
  logic issued_q;

  assign pend = issued_q || rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      issued_q <= issue;
      if (issued_q) begin
        rd_valid <= 1'b1;
        rd_data  <= arr_rdata;
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_write_backend.sv
module page_write_backend #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7,
  parameter int WCYC   = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop,
  input  logic              rq_valid,
  output logic              rq_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              arr_we,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);
  import pgc_pkg::*;

  localparam int HI_W = ADDR_W - PAGE_W;

  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic              buffered;
  logic              rd_pend;
  logic              commit_go;
  logic              commit_done;
  logic              buf_clear;
  logic              scan_act;
  logic [PAGE_W-1:0] scan_idx;
  logic [HI_W-1:0]   commit_page;
  logic [DATA_W-1:0] slot_data;
  logic              slot_vld;

  always_comb begin
    op = OP_IDLE;
    if (busy)                                     op = OP_IDLE;
    else if (stop)                                op = OP_STOP;
    else if (ld_valid)                            op = OP_LOAD;
    else if (wr_valid && !rd_pend)                op = OP_WRITE;
    else if (rq_valid && !rd_pend && !buffered)   op = OP_READ;
  end

  assign wr_ready  = !busy && !stop && !ld_valid && !rd_pend;
  assign rq_ready  = !busy && !stop && !ld_valid && !wr_valid && !rd_pend && !buffered;
  assign commit_go = (op == OP_STOP) && buffered && !wp;
  assign buf_clear = ((op == OP_STOP) && !commit_go) || (op == OP_LOAD) || commit_done;

  pgc_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ld_addr  (ld_addr),
    .cur_addr (cur_addr)
  );

  pgc_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op == OP_WRITE),
    .wr_off  (cur_addr[PAGE_W-1:0]),
    .wr_data (wr_data),
    .clear   (buf_clear),
    .rd_off  (scan_idx),
    .rd_data (slot_data),
    .rd_vld  (slot_vld),
    .any_vld (buffered)
  );

  pgc_commit_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WCYC(WCYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (commit_go),
    .page_in  (cur_addr[ADDR_W-1:PAGE_W]),
    .busy     (busy),
    .scan_act (scan_act),
    .scan_idx (scan_idx),
    .page_q   (commit_page),
    .done     (commit_done)
  );

  pgc_rd_stage #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (op == OP_READ),
    .arr_rdata (arr_rdata),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .pend      (rd_pend)
  );

  assign arr_we    = scan_act && slot_vld;
  assign arr_re    = (op == OP_READ);
  assign arr_addr  = scan_act ? {commit_page, scan_idx} : cur_addr;
  assign arr_wdata = slot_data;
endmodule

// File: rtl/page_write_backend_chk.sv
module page_write_backend_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              stop,
  input logic              ld_valid,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rq_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              arr_we,
  input logic              arr_re,
  input logic              buffered,
  input logic [ADDR_W-1:0] cur_addr
);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_ready && !rq_ready && !arr_re));

  p_ld_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_valid) |=> (cur_addr == $past(cur_addr)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_wr_in_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=>
      ((cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W])) &&
       (cur_addr[PAGE_W-1:0] == PAGE_W'($past(cur_addr[PAGE_W-1:0]) + 1'b1))));

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_re |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  p_quiet_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && (wp || !buffered)) |=> !busy);

  p_rq_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buffered |-> !rq_ready);
endmodule

bind page_write_backend page_write_backend_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wp(wp), .stop(stop), .ld_valid(ld_valid),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rq_ready(rq_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .busy(busy), .arr_we(arr_we), .arr_re(arr_re),
  .buffered(buffered), .cur_addr(cur_addr)
);

// File: tb/page_write_backend_tb_top.sv
module page_write_backend_tb_top;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int PW = 7;
  localparam int WC = 200;
  localparam int NB = 1 << AW;
  localparam int PB = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 0, ld_valid = 0, wr_valid = 0, stop = 0, rq_valid = 0, rd_ready = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rq_ready, rd_valid, busy, arr_we, arr_re;
  logic [DW-1:0] rd_data, arr_wdata, arr_q;
  logic [AW-1:0] arr_addr;

  logic [DW-1:0] mem [NB];
  logic [DW-1:0] ref_mem [NB];
  logic [DW-1:0] rbuf [PB];
  logic rmask [PB];
  int ref_addr = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  page_write_backend #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WCYC(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp(wp), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .stop(stop),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy), .arr_we(arr_we),
    .arr_re(arr_re), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
    if (arr_re) arr_q <= mem[arr_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_in_page(input int a);
    return (a & ~(PB - 1)) | ((a + 1) & (PB - 1));
  endfunction

  task automatic clear_mask();
    for (int i = 0; i < PB; i++) rmask[i] = 1'b0;
  endtask

  task automatic do_load(input int a);
    @(negedge clk); ld_valid = 1; ld_addr = AW'(a);
    @(negedge clk); ld_valid = 0;
    ref_addr = a; clear_mask();
  endtask

  task automatic do_wr(input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    #1 chk(wr_ready, "R2 wr_ready", int'(wr_ready), 1);
    @(negedge clk); wr_valid = 0;
    rbuf[ref_addr & (PB - 1)] = d;
    rmask[ref_addr & (PB - 1)] = 1'b1;
    ref_addr = next_in_page(ref_addr);
  endtask

  task automatic cmp_array(input string req);
    int miss = 0;
    for (int i = 0; i < NB; i++) if (mem[i] !== ref_mem[i]) miss++;
    chk(miss == 0, req, miss, 0);
  endtask

  task automatic do_stop(input bit w, input bit poke);
    bit any = 0;
    int n = 0;
    for (int i = 0; i < PB; i++) any |= rmask[i];
    @(negedge clk); stop = 1; wp = w;
    @(negedge clk); stop = 0; wp = 0;
    if (poke) begin
      // R7: load, stop, write and read offered while busy
      ld_valid = 1; ld_addr = AW'(ref_addr ^ 37); stop = 1; wr_valid = 1; rq_valid = 1;
      #1 chk(!wr_ready && !rq_ready, "R7 readies in busy", int'({wr_ready, rq_ready}), 0);
      n++;
      @(negedge clk); ld_valid = 0; stop = 0; wr_valid = 0; rq_valid = 0;
    end
    while (busy && n < 5000) begin n++; @(negedge clk); end
    if (any && !w) begin
      chk(n == WC, "R5 busy length", n, WC);
      for (int i = 0; i < PB; i++)
        if (rmask[i]) ref_mem[(ref_addr & ~(PB - 1)) | i] = rbuf[i];
    end else begin
      chk(n == 0, "R6 no busy", n, 0);
    end
    clear_mask();
    cmp_array(any && !w ? "R5 array" : "R6 array");
  endtask

  task automatic do_rd(input int hold);
    logic [DW-1:0] exp;
    @(negedge clk); rq_valid = 1;
    #1 chk(rq_ready, "R3 rq_ready", int'(rq_ready), 1);
    @(negedge clk); rq_valid = 0;
    @(negedge clk);
    exp = ref_mem[ref_addr];
    chk(rd_valid, "R3 rd_valid", int'(rd_valid), 1);
    chk(rd_data == exp, "R3 R4 rd_data", int'(rd_data), int'(exp));
    for (int h = 0; h < hold; h++) begin
      rq_valid = 1; wr_valid = 1;
      #1 chk(!rq_ready && !wr_ready, "R8 R10 blocked while offered",
             int'({rq_ready, wr_ready}), 0);
      @(negedge clk); rq_valid = 0; wr_valid = 0;
      chk(rd_valid && rd_data == exp, "R8 hold", int'(rd_data), int'(exp));
    end
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    ref_addr = (ref_addr + 1) % NB;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    clear_mask();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_valid, "R1 reset outputs", int'({busy, rd_valid}), 0);
    do_rd(0);                                   // R1: counter starts at 0

    do_load(3 * PB + 120);                      // R2 fold within page
    for (int i = 0; i < 20; i++) do_wr(8'($urandom));
    do_stop(0, 0);
    do_rd(1);                                   // R4 continues at folded position

    do_load(5 * PB + 10);                       // R2 overwrite after 130 bytes
    for (int i = 0; i < 130; i++) do_wr(8'($urandom));
    do_stop(0, 0);

    do_load(100);                               // R6 write protect
    for (int i = 0; i < 5; i++) do_wr(8'($urandom));
    do_stop(1, 0);
    do_load(200);                               // R6 empty stop
    do_stop(0, 0);

    do_load(300);                               // R9 load discards buffer
    for (int i = 0; i < 3; i++) do_wr(8'($urandom));
    do_load(400);
    do_stop(0, 0);
    do_rd(0);

    do_load(50);                                // R10 read blocked with bytes buffered
    do_wr(8'h5a);
    @(negedge clk); rq_valid = 1;
    #1 chk(!rq_ready, "R10 rq_ready buffered", int'(rq_ready), 0);
    @(negedge clk); rq_valid = 0;
    do_stop(0, 1);                              // R7 pokes during busy
    do_rd(0);

    do_load(NB - 4);                            // R3 wrap at array end
    for (int i = 0; i < 8; i++) do_rd(i % 2);

    for (int it = 0; it < 14; it++) begin
      if ($urandom_range(0, 1) == 0) begin
        int nb = $urandom_range(1, 140);
        do_load($urandom_range(0, NB - 1));
        for (int i = 0; i < nb; i++) do_wr(8'($urandom));
        do_stop($urandom_range(0, 3) == 0, 0);
      end else begin
        int nr = $urandom_range(1, 6);
        if ($urandom_range(0, 1) == 0) do_load($urandom_range(0, NB - 1));
        for (int i = 0; i < nr; i++) do_rd($urandom_range(0, 2));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule